// File: doc/BRIEF.md
# Redundant Controller Health Supervisor

Two identical copies of this supervisor sit in two redundant controller units that share one converter switch. Each copy publishes a 2-bit status code, watches the code its partner publishes, and decides when the partner has suffered a functional interrupt. A partner is judged failed once it has reported Offline for a parameterised number of consecutive cycles. The watching unit then raises a reconfiguration request towards the partner and keeps driving the gate alone. A unit that is itself upset floats its gate output through `gate_oe` and waits for its reconfiguration to finish.

Recovery has two phases, reconfiguration and then resynchronisation, and `mode_resync` selects how the second phase runs. In resync mode, the healthy unit hands its live duty count to the recovered unit over a one-cycle strobe, and the feedback loop is never broken. In reset mode, both units pass through a reset hold and restart from a fixed duty value. A recovered unit enables its gate only at a PWM period boundary. Both units must be given the same mode.

The state machine has these states:
- ACTIVE: driving the gate and watching the partner.
- SOLO: driving the gate alone while requesting the partner's reconfiguration.
- HANDOVER: a one-cycle duty transfer.
- OFFLINE: a local upset, waiting for reconfiguration.
- RESET: the reset hold.
- SYNC_WAIT: recovered and waiting for a duty seed.
- ARM: seeded and waiting for a period boundary.

The transitions are:
- ACTIVE→SOLO on watch expiry.
- SOLO→HANDOVER when the partner reports 00 in resync mode.
- SOLO→RESET when the partner reports 00 in reset mode.
- HANDOVER→ACTIVE.
- OFFLINE→RESET on `reconf_done`.
- RESET→SYNC_WAIT on hold expiry.
- SYNC_WAIT→ARM on a partner strobe, or in reset mode when the partner reports 00.
- ARM→ACTIVE on `pwm_wrap`.
- Any state except OFFLINE→OFFLINE on `local_upset`.

Top module: `redundant_supervisor`

## Requirements
- R1: After reset, `local_status` is 10, `gate_oe` is 1, and `reconf_req`, `xfer_strobe` and `duty_seed_valid` are 0.
- R2: The status code is 10 in ACTIVE, SOLO and HANDOVER. It is 01 in OFFLINE and RESET. It is 00 in SYNC_WAIT and ARM.
- R3: In ACTIVE, `reconf_req` goes high after the TIMEOUT_CYCLES-th consecutive clock edge at which `peer_status` was sampled as 01. Any edge that samples a different code clears the count, so shorter bursts raise no request.
- R4: While requesting, the unit keeps `gate_oe` at 1. `reconf_req` stays high while the partner reports 01, and drops in the cycle after the partner reports 00.
- R5: A sampled `local_upset` gives status 01, `gate_oe` 0 and `reconf_req` 0 from the next cycle. A unit that is not ACTIVE never starts a request, however long the partner is offline.
- R6: A `reconf_done` sampled in OFFLINE starts a reset hold. Status stays 01 for RESET_CYCLES cycles and then becomes 00.
- R7: In resync mode, a requesting unit that samples partner status 00 drives `xfer_strobe` for exactly one cycle, with `xfer_duty` equal to `duty_live`. It then returns to ACTIVE with status 10.
- R8: In SYNC_WAIT, a sampled `peer_xfer_strobe` makes `duty_seed_valid` high for one cycle, with `duty_seed` equal to the sampled `peer_xfer_duty`. Without a strobe, no seed is produced in resync mode.
- R9: In reset mode, a requesting unit that samples partner status 00 enters RESET (status 01, `gate_oe` 0). In SYNC_WAIT with partner status 00, it produces a one-cycle seed equal to DUTY_RESET.
- R10: After seeding, `gate_oe` stays 0 until `pwm_wrap` is sampled high. It rises on that same edge, and status becomes 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_resync | input | 1 | 1 = resync recovery, 0 = reset recovery |
| local_upset | input | 1 | Local functional interrupt detected |
| reconf_done | input | 1 | Pulse: local reconfiguration finished |
| pwm_wrap | input | 1 | Pulse: local PWM period boundary |
| duty_live | input | DUTY_W | Current duty count of the local loop |
| peer_status | input | 2 | Partner status code |
| peer_xfer_strobe | input | 1 | Partner duty handover strobe |
| peer_xfer_duty | input | DUTY_W | Partner duty handover value |
| local_status | output | 2 | Own status code |
| reconf_req | output | 1 | Request reconfiguration of the partner |
| gate_oe | output | 1 | Gate output enable (0 = high impedance) |
| xfer_strobe | output | 1 | Duty handover strobe to the partner |
| xfer_duty | output | DUTY_W | Duty handover value (0 when idle) |
| duty_seed | output | DUTY_W | Value to load into the local loop |
| duty_seed_valid | output | 1 | One-cycle load pulse for `duty_seed` |

## Verification
The bench targets the watch-timer boundary: bursts one cycle shorter than the timeout, an exact-length burst, and a short burst broken by one active cycle. A timer that does not clear, or that is off by one, shows up as a missing or spurious request. It checks that an offline unit stays silent while its partner is also offline, since a design that lets it request would let the two units reconfigure each other. It holds `pwm_wrap` low for random spans after seeding, which exposes a design that enables the gate early. It also runs both recovery modes, where a wrong seed value, a strobe that lasts more than one cycle, or a reset hold of the wrong length is visible at the ports.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_SOLO,
        ST_HANDOVER,
        ST_OFFLINE,
        ST_RESET,
        ST_SYNC_WAIT,
        ST_ARM
    } sup_state_e;

    localparam logic [1:0] STAT_RECOV   = 2'b00;
    localparam logic [1:0] STAT_OFFLINE = 2'b01;
    localparam logic [1:0] STAT_ACTIVE  = 2'b10;

endpackage

// File: rtl/sup_cycle_timer.sv
module sup_cycle_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sup_seed_reg.sv
module sup_seed_reg #(
    parameter int unsigned DUTY_W     = 8,
    parameter logic [DUTY_W-1:0] DUTY_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_peer,
    input  logic              load_default,
    input  logic [DUTY_W-1:0] peer_duty,
    output logic [DUTY_W-1:0] seed,
    output logic              seed_valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed       <= DUTY_RESET;
            seed_valid <= 1'b0;
        end else begin
            seed_valid <= load_peer || load_default;
            if (load_peer) begin
                seed <= peer_duty;
            end else if (load_default) begin
                seed <= DUTY_RESET;
            end
        end
    end

    AST_SEED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seed_valid |=> !seed_valid); // R8

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_resync,
    input  logic       local_upset,
    input  logic       reconf_done,
    input  logic       pwm_wrap,
    input  logic [1:0] peer_status,
    input  logic       peer_xfer_strobe,
    input  logic       watch_expired,
    input  logic       hold_expired,
    output logic       watch_run,
    output logic       hold_run,
    output logic       load_peer,
    output logic       load_default,
    output logic [1:0] local_status,
    output logic       reconf_req,
    output logic       gate_oe,
    output logic       xfer_strobe
);
    sup_state_e state_q, state_d;

    logic peer_offline;
    logic peer_recov;

    assign peer_offline = (peer_status == STAT_OFFLINE);
    assign peer_recov   = (peer_status == STAT_RECOV);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer control
    always_comb begin
        state_d      = state_q;
        load_peer    = 1'b0;
        load_default = 1'b0;
        watch_run    = 1'b0;
        hold_run     = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                watch_run = peer_offline && !local_upset;
                if (local_upset) begin
                    state_d = ST_OFFLINE;
                end else if (watch_expired) begin
                    state_d = ST_SOLO;
                end
            end
            ST_SOLO: begin
                if (local_upset) begin
                    state_d = ST_OFFLINE;
                end else if (peer_recov) begin
                    state_d = mode_resync ? ST_HANDOVER : ST_RESET;
                end
            end
            ST_HANDOVER: begin
                state_d = local_upset ? ST_OFFLINE : ST_ACTIVE;
            end
            ST_OFFLINE: begin
                if (reconf_done) begin
                    state_d = ST_RESET;
                end
            end
            ST_RESET: begin
                hold_run = !local_upset;
                if (local_upset) begin
                    state_d = ST_OFFLINE;
                end else if (hold_expired) begin
                    state_d = ST_SYNC_WAIT;
                end
            end
            ST_SYNC_WAIT: begin
                if (local_upset) begin
                    state_d = ST_OFFLINE;
                end else if (peer_xfer_strobe) begin
                    state_d   = ST_ARM;
                    load_peer = 1'b1;
                end else if (!mode_resync && peer_recov) begin
                    state_d      = ST_ARM;
                    load_default = 1'b1;
                end
            end
            ST_ARM: begin
                if (local_upset) begin
                    state_d = ST_OFFLINE;
                end else if (pwm_wrap) begin
                    state_d = ST_ACTIVE;
                end
            end
            default: state_d = ST_OFFLINE;
        endcase
    end

    // Output decode
    always_comb begin
        local_status = STAT_OFFLINE;
        reconf_req   = 1'b0;
        gate_oe      = 1'b0;
        xfer_strobe  = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                local_status = STAT_ACTIVE;
                gate_oe      = 1'b1;
            end
            ST_SOLO: begin
                local_status = STAT_ACTIVE;
                gate_oe      = 1'b1;
                reconf_req   = 1'b1;
            end
            ST_HANDOVER: begin
                local_status = STAT_ACTIVE;
                gate_oe      = 1'b1;
                xfer_strobe  = 1'b1;
            end
            ST_OFFLINE, ST_RESET: begin
                local_status = STAT_OFFLINE;
            end
            ST_SYNC_WAIT, ST_ARM: begin
                local_status = STAT_RECOV;
            end
            default: local_status = STAT_OFFLINE;
        endcase
    end

    AST_REQ_AFTER_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reconf_req) |-> $past(peer_status) == STAT_OFFLINE); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf_req && peer_offline && !local_upset) |=> reconf_req); // R4

    AST_UPSET_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        local_upset |=> (!gate_oe && !reconf_req && local_status == STAT_OFFLINE)); // R5

    AST_HANDOVER_AFTER_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_strobe) |-> $past(peer_status) == STAT_RECOV); // R7

    AST_OE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_oe) |-> $past(pwm_wrap)); // R10

endmodule

// File: rtl/redundant_supervisor.sv
module redundant_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned DUTY_W         = 8,
    parameter int unsigned TIMEOUT_CYCLES = 8,
    parameter int unsigned RESET_CYCLES   = 4,
    parameter logic [DUTY_W-1:0] DUTY_RESET = DUTY_W'(64)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_resync,
    input  logic              local_upset,
    input  logic              reconf_done,
    input  logic              pwm_wrap,
    input  logic [DUTY_W-1:0] duty_live,
    input  logic [1:0]        peer_status,
    input  logic              peer_xfer_strobe,
    input  logic [DUTY_W-1:0] peer_xfer_duty,
    output logic [1:0]        local_status,
    output logic              reconf_req,
    output logic              gate_oe,
    output logic              xfer_strobe,
    output logic [DUTY_W-1:0] xfer_duty,
    output logic [DUTY_W-1:0] duty_seed,
    output logic              duty_seed_valid
);
    logic watch_run, watch_expired;
    logic hold_run, hold_expired;
    logic load_peer, load_default;

    sup_cycle_timer #(.LIMIT(TIMEOUT_CYCLES)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (watch_run),
        .expired (watch_expired)
    );

    sup_cycle_timer #(.LIMIT(RESET_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_run),
        .expired (hold_expired)
    );

    sup_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .mode_resync      (mode_resync),
        .local_upset      (local_upset),
        .reconf_done      (reconf_done),
        .pwm_wrap         (pwm_wrap),
        .peer_status      (peer_status),
        .peer_xfer_strobe (peer_xfer_strobe),
        .watch_expired    (watch_expired),
        .hold_expired     (hold_expired),
        .watch_run        (watch_run),
        .hold_run         (hold_run),
        .load_peer        (load_peer),
        .load_default     (load_default),
        .local_status     (local_status),
        .reconf_req       (reconf_req),
        .gate_oe          (gate_oe),
        .xfer_strobe      (xfer_strobe)
    );

    sup_seed_reg #(.DUTY_W(DUTY_W), .DUTY_RESET(DUTY_RESET)) u_seed (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_peer    (load_peer),
        .load_default (load_default),
        .peer_duty    (peer_xfer_duty),
        .seed         (duty_seed),
        .seed_valid   (duty_seed_valid)
    );

    assign xfer_duty = xfer_strobe ? duty_live : '0;

    AST_SEED_WHILE_FLOATING: assert property (@(posedge clk) disable iff (!rst_n)
        duty_seed_valid |-> !gate_oe); // R10

endmodule

// File: tb/redundant_supervisor_bench.sv
module redundant_supervisor_bench;
    localparam int unsigned DW = 8;
    localparam int unsigned TO = 8;
    localparam int unsigned HOLD = 4;
    localparam logic [DW-1:0] DRST = 8'd64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_resync = 1'b1, local_upset = 1'b0, reconf_done = 1'b0, pwm_wrap = 1'b0;
    logic [DW-1:0] duty_live = '0, peer_xfer_duty = '0;
    logic [1:0] peer_status = 2'b10;
    logic peer_xfer_strobe = 1'b0;
    logic [1:0] local_status;
    logic reconf_req, gate_oe, xfer_strobe, duty_seed_valid;
    logic [DW-1:0] xfer_duty, duty_seed;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    redundant_supervisor #(.DUTY_W(DW), .TIMEOUT_CYCLES(TO), .RESET_CYCLES(HOLD),
                           .DUTY_RESET(DRST)) u_redundant_supervisor (
        .clk(clk), .rst_n(rst_n), .mode_resync(mode_resync), .local_upset(local_upset),
        .reconf_done(reconf_done), .pwm_wrap(pwm_wrap), .duty_live(duty_live),
        .peer_status(peer_status), .peer_xfer_strobe(peer_xfer_strobe),
        .peer_xfer_duty(peer_xfer_duty), .local_status(local_status),
        .reconf_req(reconf_req), .gate_oe(gate_oe), .xfer_strobe(xfer_strobe),
        .xfer_duty(xfer_duty), .duty_seed(duty_seed), .duty_seed_valid(duty_seed_valid)
    );

    function automatic bit expect_request(int unsigned burst);
        return burst >= TO;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_solo();
        peer_status = 2'b01;
        repeat (TO - 1) tick();
        chk("R3 no request one cycle early", 32'(reconf_req), 0);
        tick();
        chk("R3 request at timeout", 32'(reconf_req), 1);
        chk("R4 keeps gate while requesting", 32'(gate_oe), 1);
        tick();
        chk("R4 request held", 32'(reconf_req), 1);
    endtask

    task automatic heal_resync();
        mode_resync = 1'b1;
        duty_live = DW'($urandom);
        peer_status = 2'b00;
        tick();
        chk("R4 request drops", 32'(reconf_req), 0);
        chk("R7 strobe", 32'(xfer_strobe), 1);
        chk("R7 duty handed over", 32'(xfer_duty), 32'(duty_live));
        tick();
        chk("R7 strobe one cycle", 32'(xfer_strobe), 0);
        chk("R2 back to active code", 32'(local_status), 32'h2);
        peer_status = 2'b10;
    endtask

    task automatic finish_rearm(logic [DW-1:0] seed_exp, string tag);
        chk({tag, " seed pulse"}, 32'(duty_seed_valid), 1);
        chk({tag, " seed value"}, 32'(duty_seed), 32'(seed_exp));
        chk("R10 gate floats when seeded", 32'(gate_oe), 0);
        for (int w = $urandom_range(0, 3); w > 0; w--) begin
            tick();
            chk("R10 gate waits for boundary", 32'(gate_oe), 0);
            chk("R8 seed one cycle", 32'(duty_seed_valid), 0);
        end
        pwm_wrap = 1'b1;
        tick();
        pwm_wrap = 1'b0;
        chk("R10 gate at boundary", 32'(gate_oe), 1);
        chk("R2 active after arm", 32'(local_status), 32'h2);
    endtask

    task automatic heal_reset();
        mode_resync = 1'b0;
        peer_status = 2'b00;
        tick();
        chk("R9 enters reset", 32'(local_status), 32'h1);
        chk("R9 gate floats", 32'(gate_oe), 0);
        repeat (HOLD - 1) tick();
        chk("R6 hold length", 32'(local_status), 32'h1);
        tick();
        chk("R6 hold ends", 32'(local_status), 32'h0);
        tick();
        finish_rearm(DRST, "R9");
        peer_status = 2'b10;
    endtask

    task automatic local_fault(bit resync);
        local_upset = 1'b1;
        tick();
        local_upset = 1'b0;
        chk("R5 offline code", 32'(local_status), 32'h1);
        chk("R5 gate floats", 32'(gate_oe), 0);
        chk("R5 request off", 32'(reconf_req), 0);
        peer_status = 2'b01;
        repeat (TO + 2) tick();
        chk("R5 no mutual request", 32'(reconf_req), 0);
        peer_status = 2'b10;
        reconf_done = 1'b1;
        tick();
        reconf_done = 1'b0;
        repeat (HOLD - 1) tick();
        chk("R6 hold code", 32'(local_status), 32'h1);
        tick();
        chk("R6 recovering code", 32'(local_status), 32'h0);
        mode_resync = resync;
        if (resync) begin
            repeat (2) tick();
            chk("R8 waits for strobe", 32'(duty_seed_valid), 0);
            peer_xfer_duty = DW'($urandom);
            peer_xfer_strobe = 1'b1;
            tick();
            peer_xfer_strobe = 1'b0;
            finish_rearm(peer_xfer_duty, "R8");
        end else begin
            peer_status = 2'b00;
            tick();
            peer_status = 2'b10;
            finish_rearm(DRST, "R9");
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) tick();
        chk("R1 reset status", 32'(local_status), 32'h2);
        chk("R1 reset gate", 32'(gate_oe), 1);
        chk("R1 reset request", 32'(reconf_req), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle strobe", 32'(xfer_strobe), 0);
        chk("R1 idle seed", 32'(duty_seed_valid), 0);

        // R3: broken burst clears the timer
        peer_status = 2'b01;
        repeat (TO - 1) tick();
        peer_status = 2'b10;
        tick();
        peer_status = 2'b01;
        repeat (TO - 1) tick();
        chk("R3 timer cleared", 32'(reconf_req), 0);
        peer_status = 2'b10;
        tick();

        go_solo();
        heal_resync();
        go_solo();
        heal_reset();
        local_fault(1'b1);
        local_fault(1'b0);

        // R5: upset while requesting
        go_solo();
        local_upset = 1'b1;
        tick();
        local_upset = 1'b0;
        chk("R5 upset drops request", 32'(reconf_req), 0);
        peer_status = 2'b10;
        reconf_done = 1'b1;
        tick();
        reconf_done = 1'b0;
        repeat (HOLD) tick();
        peer_xfer_duty = 8'h3C;
        peer_xfer_strobe = 1'b1;
        tick();
        peer_xfer_strobe = 1'b0;
        finish_rearm(8'h3C, "R8");

        for (int it = 0; it < 24; it++) begin
            int unsigned len = $urandom_range(1, TO + 2);
            peer_status = 2'b01;
            repeat (len) tick();
            chk("R3 random burst", 32'(reconf_req), 32'(expect_request(len)));
            if (expect_request(len)) begin
                if ($urandom_range(0, 1) == 1) heal_resync();
                else heal_reset();
            end else begin
                peer_status = 2'b10;
                tick();
                chk("R3 short burst quiet", 32'(reconf_req), 0);
            end
            if ($urandom_range(0, 4) == 0) local_fault(1'($urandom_range(0, 1)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule